// File: doc/BRIEF.md
# PC-Relative Conditional Jump Unit

This unit resolves the conditional jump instructions of a 16-bit processor. Each cycle it takes the instruction word, the address of that instruction and the four condition flags (negative, zero, carry, overflow). It reports whether the word is a jump, whether the jump is taken, and which program counter comes next. A taken jump goes to its PC-relative target. Every other case goes to the sequential address.

A jump word carries the class code `001` in its top three bits, a three-bit condition selector below that, and a signed ten-bit offset in the low bits. The offset counts words. It is doubled and added to the address of the following instruction. Signed "greater or equal" and "less than" tests compare N against V. The unit only reads the flags and never writes them.

The three results are registered. A set of inputs presented before a rising clock edge appears on the outputs just after that edge. A synchronous active-low reset clears all outputs.

Top module: `jmpu_branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge leaves `is_jump_o` = 0, `taken_o` = 0 and `next_pc_o` = 0.
- R2: After each rising edge with `rst_n` high, `is_jump_o` is 1 exactly when `instr_i[15:13]` was `3'b001` at that edge, and `taken_o` is never 1 while `is_jump_o` is 0.
- R3: For a jump word, `instr_i[12:10]` selects the taken rule: 0 takes when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=1, 5 when N xor V = 0, 6 when N xor V = 1, and 7 always takes.
- R4: A taken jump sets `next_pc_o` to (PC + 2 + 2 × sign-extended `instr_i[9:0]`) mod 2^16, with bit 0 cleared.
- R5: A jump whose condition fails sets `next_pc_o` to (PC + 2) mod 2^16, with bit 0 cleared.
- R6: A word whose bits 15:13 are not `3'b001` gives `is_jump_o` = 0, `taken_o` = 0 and `next_pc_o` = PC + 2 (bit 0 cleared), whatever its other bits and the flags are.
- R7: Offset `10'h1FF` lands 512 words after the jump's own address, and offset `10'h200` lands 511 words before it.
- R8: Address sums wrap modulo 2^16 in both directions. An odd `pc_i` still yields an even `next_pc_o`, equal to the result computed from `pc_i` with its bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 16 | Instruction word under evaluation |
| pc_i | input | 16 | Address of that instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| is_jump_o | output | 1 | Registered: word was a jump |
| taken_o | output | 1 | Registered: jump taken |
| next_pc_o | output | 16 | Registered: following program counter |

## Verification
Two cases are hard to reach from the ports: targets that wrap past either end of the address space, and targets at exactly the outermost offsets. A random instruction stream seldom pairs an address near 0x0000 or 0xFFFE with an extreme offset. The stimulus therefore sweeps all 1024 offsets under an unconditional jump at several base addresses, including both ends of the space and an odd address. It also crosses every condition code with all sixteen flag combinations, and every non-jump class code with the same flag set.

// File: rtl/jmpu_pkg.sv
package jmpu_pkg;

    // Class code held in the three most significant instruction bits
    localparam logic [2:0] JMP_CLASS = 3'b001;
    localparam int unsigned CLASS_W  = 3;
    localparam int unsigned COND_W   = 3;

    // Condition selector values (behaviour depends on this order)
    typedef enum logic [COND_W-1:0] {
        CC_ZERO_CLR = 3'd0,
        CC_ZERO_SET = 3'd1,
        CC_CARRY_CLR = 3'd2,
        CC_CARRY_SET = 3'd3,
        CC_NEG_SET  = 3'd4,
        CC_SGN_GE   = 3'd5,
        CC_SGN_LT   = 3'd6,
        CC_ALWAYS   = 3'd7
    } jcc_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/jmpu_decode.sv
module jmpu_decode
    import jmpu_pkg::*;
#(
    parameter int unsigned OFF_W = 10
) (
    input  logic [OFF_W+CLASS_W+COND_W-1:0] instr_i,
    output logic                            is_jump_o,
    output jcc_e                            cond_o,
    output logic [OFF_W-1:0]                offset_o
);
    localparam int unsigned COND_LSB  = OFF_W;
    localparam int unsigned CLASS_LSB = OFF_W + COND_W;
    localparam int unsigned INSTR_W   = CLASS_LSB + CLASS_W;

    always_comb begin
        is_jump_o = (instr_i[INSTR_W-1:CLASS_LSB] == JMP_CLASS);
        cond_o    = jcc_e'(instr_i[CLASS_LSB-1:COND_LSB]);
        offset_o  = instr_i[OFF_W-1:0];
    end
endmodule

// File: rtl/jmpu_cond.sv
module jmpu_cond
    import jmpu_pkg::*;
(
    input  logic   is_jump_i,
    input  jcc_e   cond_i,
    input  flags_t flags_i,
    output logic   take_o
);
    logic cond_met;

    always_comb begin
        cond_met = 1'b0;
        unique case (cond_i)
            CC_ZERO_CLR:  cond_met = ~flags_i.z;
            CC_ZERO_SET:  cond_met =  flags_i.z;
            CC_CARRY_CLR: cond_met = ~flags_i.c;
            CC_CARRY_SET: cond_met =  flags_i.c;
            CC_NEG_SET:   cond_met =  flags_i.n;
            CC_SGN_GE:    cond_met = ~(flags_i.n ^ flags_i.v);
            CC_SGN_LT:    cond_met =  (flags_i.n ^ flags_i.v);
            CC_ALWAYS:    cond_met = 1'b1;
            default:      cond_met = 1'b0;
        endcase
        take_o = is_jump_i & cond_met;
    end
endmodule

// File: rtl/jmpu_target.sv
module jmpu_target #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFF_W  = 10
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] seq_pc_o,
    output logic [ADDR_W-1:0] tgt_pc_o
);
    localparam int unsigned EXT_W = ADDR_W - OFF_W - 1;
    localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] EVEN_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic [ADDR_W-1:0] byte_disp;
    logic [ADDR_W-1:0] after_jump;

    always_comb begin
        // sign-extend the word count and scale to bytes
        byte_disp  = {{EXT_W{offset_i[OFF_W-1]}}, offset_i, 1'b0};
        after_jump = pc_i + STEP;
        seq_pc_o   = after_jump & EVEN_MASK;
        tgt_pc_o   = (after_jump + byte_disp) & EVEN_MASK;
    end
endmodule

// File: rtl/jmpu_branch_unit.sv
module jmpu_branch_unit
    import jmpu_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFF_W  = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [OFF_W+CLASS_W+COND_W-1:0] instr_i,
    input  logic [ADDR_W-1:0]               pc_i,
    input  logic                            flag_n_i,
    input  logic                            flag_z_i,
    input  logic                            flag_c_i,
    input  logic                            flag_v_i,
    output logic                            is_jump_o,
    output logic                            taken_o,
    output logic [ADDR_W-1:0]               next_pc_o
);
    localparam int unsigned INSTR_W   = OFF_W + CLASS_W + COND_W;
    localparam int unsigned CLASS_LSB = OFF_W + COND_W;
    localparam logic [ADDR_W-1:0] EVEN_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic              dec_jump;
    jcc_e              dec_cond;
    logic [OFF_W-1:0]  dec_off;
    logic              take_now;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt_pc;
    logic [ADDR_W-1:0] pick_pc;
    flags_t            flags;

    assign flags = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

    jmpu_decode #(.OFF_W(OFF_W)) u_decode (
        .instr_i   (instr_i),
        .is_jump_o (dec_jump),
        .cond_o    (dec_cond),
        .offset_o  (dec_off)
    );

    jmpu_cond u_cond (
        .is_jump_i (dec_jump),
        .cond_i    (dec_cond),
        .flags_i   (flags),
        .take_o    (take_now)
    );

    jmpu_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_target (
        .pc_i     (pc_i),
        .offset_i (dec_off),
        .seq_pc_o (seq_pc),
        .tgt_pc_o (tgt_pc)
    );

    always_comb begin
        pick_pc = take_now ? tgt_pc : seq_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_jump_o <= 1'b0;
            taken_o   <= 1'b0;
            next_pc_o <= '0;
        end else begin
            is_jump_o <= dec_jump;
            taken_o   <= take_now;
            next_pc_o <= pick_pc;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!is_jump_o && !taken_o && next_pc_o == '0)); // R1

    AST_TAKEN_NEEDS_JUMP: assert property (@(posedge clk) disable iff (!rst_n) taken_o |-> is_jump_o); // R2

    AST_JUMP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (instr_i[INSTR_W-1:CLASS_LSB] == JMP_CLASS) |=> is_jump_o); // R2

    AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (instr_i[INSTR_W-1:OFF_W] == 6'b001111) |=> taken_o); // R3

    AST_ZERO_SET_RULE: assert property (@(posedge clk) disable iff (!rst_n) (instr_i[INSTR_W-1:OFF_W] == 6'b001001) |=> (taken_o == $past(flag_z_i))); // R3

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (instr_i[INSTR_W-1:CLASS_LSB] == JMP_CLASS) |=> (!taken_o || next_pc_o == ((ADDR_W'($past(pc_i)) + ADDR_W'(2) + ADDR_W'($signed($past(instr_i[OFF_W-1:0])) * 2)) & EVEN_MASK))); // R4

    AST_FAILED_SEQ: assert property (@(posedge clk) disable iff (!rst_n) (instr_i[INSTR_W-1:CLASS_LSB] == JMP_CLASS) |=> (taken_o || next_pc_o == (($past(pc_i) + ADDR_W'(2)) & EVEN_MASK))); // R5

    AST_NONJUMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (instr_i[INSTR_W-1:CLASS_LSB] != JMP_CLASS) |=> (!is_jump_o && !taken_o && next_pc_o == (($past(pc_i) + ADDR_W'(2)) & EVEN_MASK))); // R6

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n) next_pc_o[0] == 1'b0); // R8

endmodule

// File: tb/tb_jmpu_branch_unit.sv
module tb_jmpu_branch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;
    logic [15:0] pc = 16'h0000;
    logic        fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
    logic        is_jump, taken;
    logic [15:0] next_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    jmpu_branch_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr),
        .pc_i      (pc),
        .flag_n_i  (fn),
        .flag_z_i  (fz),
        .flag_c_i  (fc),
        .flag_v_i  (fv),
        .is_jump_o (is_jump),
        .taken_o   (taken),
        .next_pc_o (next_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic bit model_take(input int cc, input bit n, input bit z, input bit c, input bit v);
        if (cc == 0) return !z;
        if (cc == 1) return z;
        if (cc == 2) return !c;
        if (cc == 3) return c;
        if (cc == 4) return n;
        if (cc == 5) return n == v;
        if (cc == 6) return n != v;
        return 1'b1;
    endfunction

    function automatic int model_target(input int base, input int off10);
        int words;
        int t;
        words = (off10 >= 512) ? off10 - 1024 : off10;
        t = (base & 32'hFFFE) + 2 + 2 * words;
        t = ((t % 65536) + 65536) % 65536;
        return t & 32'hFFFE;
    endfunction

    function automatic int model_seq(input int base);
        return ((base & 32'hFFFE) + 2) % 65536;
    endfunction

    // apply inputs at a falling edge, sample after the following rising edge
    task automatic apply(input logic [15:0] w, input logic [15:0] p, input logic [3:0] f);
        instr = w; pc = p;
        fn = f[3]; fz = f[2]; fc = f[1]; fv = f[0];
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int pcs[4];
        pcs[0] = 16'h4000; pcs[1] = 16'h0000; pcs[2] = 16'hFFFE; pcs[3] = 16'h1235;

        // R1: outputs held clear while reset is low, with busy inputs
        @(negedge clk);
        instr = 16'h3C05; pc = 16'h8000; fn = 1; fz = 1; fc = 1; fv = 1;
        repeat (3) @(negedge clk);
        check("R1", "is_jump in reset", int'(is_jump), 0);
        check("R1", "taken in reset", int'(taken), 0);
        check("R1", "next_pc in reset", int'(next_pc), 0);
        rst_n = 1'b1;

        // R3 R4 R5 R2: every condition against every flag combination
        for (int cc = 0; cc < 8; cc++) begin
            for (int f = 0; f < 16; f++) begin
                for (int k = 0; k < 4; k++) begin
                    int off;
                    bit et;
                    logic [15:0] w;
                    off = (cc * 37 + f * 11 + k * 101) % 1024;
                    w = {3'b001, 3'(cc), 10'(off)};
                    apply(w, 16'(pcs[k]), 4'(f));
                    et = model_take(cc, f[3], f[2], f[1], f[0]);
                    check("R2", "is_jump on jump word", int'(is_jump), 1);
                    check("R3", $sformatf("taken cc=%0d flags=%0h", cc, f), int'(taken), int'(et));
                    if (et) check("R4", "taken target", int'(next_pc), model_target(pcs[k], off));
                    else    check("R5", "fall-through pc", int'(next_pc), model_seq(pcs[k]));
                end
            end
        end

        // R6: every other class code, any flags, any low bits
        for (int cls = 0; cls < 8; cls++) begin
            if (cls == 1) continue;
            for (int f = 0; f < 16; f++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [12:0] low;
                    low = 13'((cls * 977 + f * 313 + k * 59) % 8192);
                    apply({3'(cls), low}, 16'(pcs[k]), 4'(f));
                    check("R6", "is_jump non-jump", int'(is_jump), 0);
                    check("R6", "taken non-jump", int'(taken), 0);
                    check("R6", "next_pc non-jump", int'(next_pc), model_seq(pcs[k]));
                end
            end
        end

        // R4 R8: full offset sweep under the unconditional code, incl. wrap and odd base
        for (int k = 0; k < 4; k++) begin
            for (int off = 0; off < 1024; off++) begin
                apply({6'b001111, 10'(off)}, 16'(pcs[k]), 4'h0);
                check(k == 0 ? "R4" : "R8", $sformatf("target off=%0h pc=%0h", off, pcs[k]),
                      int'(next_pc), model_target(pcs[k], off));
            end
        end

        // R7: outermost offsets relative to the jump's own address
        apply(16'h3DFF, 16'h4000, 4'h0);
        check("R7", "offset +512 words", int'(next_pc), 16'h4400);
        apply(16'h3E00, 16'h4000, 4'h0);
        check("R7", "offset -511 words", int'(next_pc), 16'h3C02);

        // R8: explicit wrap points and odd base
        apply(16'h3C01, 16'hFFFE, 4'h0);
        check("R8", "wrap forward", int'(next_pc), 16'h0002);
        apply(16'h3E00, 16'h0000, 4'h0);
        check("R8", "wrap backward", int'(next_pc), 16'hFC02);
        apply(16'h0000, 16'hFFFF, 4'h0);
        check("R8", "odd pc sequential", int'(next_pc), 16'h0000);

        // R1 again: reset reasserted mid-run clears outputs
        instr = 16'h3C10; pc = 16'h2222;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "taken after reassert", int'(taken), 0);
        check("R1", "next_pc after reassert", int'(next_pc), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", "jump after reset release", int'(is_jump), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule